// File: doc/BRIEF.md
# Posted-Write Bus Bridge

This block sits between a processor-side bus master port and a segment of slower peripherals. It cuts the long combinational paths of a flat data bus by registering both directions: requests are captured into registers before they are sent downstream, and read data is captured into a register before it goes back upstream. The same module is placed once per peripheral segment. The address window that an instance answers is set by two parameters: a base value and a mask. Peripherals can therefore be moved from one bridge instance to another without changing the RTL.

Writes are posted. When the bridge is idle, it acknowledges the master one cycle after it accepts the write. It then forwards the write downstream while the master goes on with other work. Reads block. The request is forwarded, and the master waits until the downstream data has been captured. The master acknowledge is raised in the same cycle that the captured data appears. Between reads the returned-data register keeps its last value.

The controller has four states:
- `ST_IDLE` waits for a request in the window.
- `ST_WPOST` forwards a posted write.
- `ST_RWAIT` forwards a read and waits for the slave.
- `ST_RDONE` is a one-cycle recovery state after a read acknowledge.

The transitions are:
- accept-write: `ST_IDLE`→`ST_WPOST`
- accept-read: `ST_IDLE`→`ST_RWAIT`
- write-done: `ST_WPOST`→`ST_IDLE` on the slave acknowledge
- read-done: `ST_RWAIT`→`ST_RDONE` on the slave acknowledge
- recover: `ST_RDONE`→`ST_IDLE`, unconditional

Top module: `posted_bridge`

## Requirements
- R1: Reset is synchronous and active high. After a clock edge with `rst` high, `m_ack`, `s_cyc` and `s_stb` are 0 and `m_rdat` is 0.
- R2: A request is accepted only in `ST_IDLE`, and only when `m_cyc`, `m_stb` and the window test `(m_adr & WIN_MASK) == WIN_BASE` are all true. With the default window, the test is `(m_adr & 32'hFFFF0000) == 32'h00020000`. A request outside the window never raises `m_ack`, `s_cyc` or `s_stb`.
- R3: A write accepted in idle raises `m_ack` in the cycle right after the accepting edge, before the downstream transfer finishes.
- R4: After a write is accepted, `s_cyc`, `s_stb` and `s_we` are 1 from the next cycle until the edge that samples `s_ack`. `s_adr` and `s_wdat` carry the accepted address and data. Writes reach the slave in the order they were accepted.
- R5: While a posted write is still being forwarded, new master requests get no `m_ack`. A write issued right after a previous write's acknowledge completes exactly `L` cycles after it was issued, where the slave needs `L` cycles.
- R6: A read is forwarded with `s_we` at 0. In the cycle after the edge that samples `s_ack`, `m_ack` is 1 and `m_rdat` equals the `s_rdat` value sampled at that edge. With a slave that acknowledges `L` cycles after `s_stb` rises, the master sees `m_ack` `L+1` cycles after driving an idle request.
- R7: `m_ack` is a single-cycle pulse: it is never high for two consecutive cycles.
- R8: `m_rdat` changes only in the cycle after a read's `s_ack`. It holds its value through writes and idle cycles, whatever `s_rdat` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | 1 | Master bus cycle active |
| m_stb | input | 1 | Master request strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | AW | Master address |
| m_wdat | input | DW | Master write data |
| m_ack | output | 1 | Acknowledge to master, one-cycle pulse |
| m_rdat | output | DW | Registered read data, holds between reads |
| s_cyc | output | 1 | Downstream cycle active |
| s_stb | output | 1 | Downstream strobe |
| s_we | output | 1 | Downstream write enable |
| s_adr | output | AW | Downstream address (registered) |
| s_wdat | output | DW | Downstream write data (registered) |
| s_ack | input | 1 | Downstream acknowledge |
| s_rdat | input | DW | Downstream read data |

## Verification
The hardest case to reach from the ports is a request that arrives while a posted write is still in flight. The master has already seen its acknowledge, so only the stall cycles show that the bridge is busy. The bench reaches this case by making the slave slow (six cycles) and issuing a second write on the cycle after the first acknowledge. It then checks that the second write completes after exactly the slave latency and that both writes reach the slave in order. Between transfers the slave drives changing data on `s_rdat`, so any leak into the held read register shows up at once.

// File: rtl/pb_pkg.sv
package pb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WPOST,
        ST_RWAIT,
        ST_RDONE
    } pb_state_e;
endpackage

// File: rtl/pb_window.sv
module pb_window #(
    parameter int          AW   = 32,
    parameter logic [AW-1:0] BASE = '0,
    parameter logic [AW-1:0] MASK = '0
) (
    input  logic [AW-1:0] adr,
    output logic          hit
);
    // Address is inside this instance's window when the masked bits match
    assign hit = ((adr & MASK) == BASE);
endmodule

// File: rtl/pb_ctrl.sv
module pb_ctrl
    import pb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      req_we,
    input  logic      dn_ack,
    output pb_state_e state,
    output logic      take,
    output logic      rd_cap,
    output logic      dn_act,
    output logic      up_ack
);
    pb_state_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req) nxt = req_we ? ST_WPOST : ST_RWAIT;
            ST_WPOST: if (dn_ack) nxt = ST_IDLE;
            ST_RWAIT: if (dn_ack) nxt = ST_RDONE;
            ST_RDONE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Decoded controls
    always_comb begin
        take   = (state == ST_IDLE) && req;
        rd_cap = (state == ST_RWAIT) && dn_ack;
        dn_act = (state == ST_WPOST) || (state == ST_RWAIT);
    end

    // Registered upstream acknowledge
    always_ff @(posedge clk) begin
        if (rst) up_ack <= 1'b0;
        else     up_ack <= (take && req_we) || rd_cap;
    end

    // R3: a write taken in idle is acknowledged on the next cycle
    a_r3_posted_ack: assert property (@(posedge clk) disable iff (rst)
        (take && req_we) |=> up_ack);

    // R7: acknowledge never lasts two cycles
    a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        up_ack |=> !up_ack);
endmodule

// File: rtl/pb_rdret.sv
module pb_rdret #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    // Return register: loads only on a read completion, holds otherwise
    always_ff @(posedge clk) begin
        if (rst)      dout <= '0;
        else if (cap) dout <= din;
    end
endmodule

// File: rtl/posted_bridge.sv
module posted_bridge
    import pb_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DW       = 32,
    parameter logic [AW-1:0] WIN_BASE = 32'h0002_0000,
    parameter logic [AW-1:0] WIN_MASK = 32'hFFFF_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          m_cyc,
    input  logic          m_stb,
    input  logic          m_we,
    input  logic [AW-1:0] m_adr,
    input  logic [DW-1:0] m_wdat,
    output logic          m_ack,
    output logic [DW-1:0] m_rdat,
    output logic          s_cyc,
    output logic          s_stb,
    output logic          s_we,
    output logic [AW-1:0] s_adr,
    output logic [DW-1:0] s_wdat,
    input  logic          s_ack,
    input  logic [DW-1:0] s_rdat
);
    logic      win_hit;
    logic      req;
    logic      take;
    logic      rd_cap;
    logic      dn_act;
    pb_state_e state;

    pb_window #(.AW(AW), .BASE(WIN_BASE), .MASK(WIN_MASK)) i_win (
        .adr (m_adr),
        .hit (win_hit)
    );

    assign req = m_cyc && m_stb && win_hit;

    pb_ctrl i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .req_we (m_we),
        .dn_ack (s_ack),
        .state  (state),
        .take   (take),
        .rd_cap (rd_cap),
        .dn_act (dn_act),
        .up_ack (m_ack)
    );

    // Downstream request registers, loaded when a request is taken
    always_ff @(posedge clk) begin
        if (rst) begin
            s_adr  <= '0;
            s_wdat <= '0;
            s_we   <= 1'b0;
        end else if (take) begin
            s_adr  <= m_adr;
            s_wdat <= m_wdat;
            s_we   <= m_we;
        end
    end

    assign s_cyc = dn_act;
    assign s_stb = dn_act;

    pb_rdret #(.DW(DW)) i_ret (
        .clk  (clk),
        .rst  (rst),
        .cap  (rd_cap),
        .din  (s_rdat),
        .dout (m_rdat)
    );

    // R2: out-of-window requests in idle cause no ack and no downstream cycle
    a_r2_window: assert property (@(posedge clk) disable iff (rst)
        (m_cyc && m_stb && !win_hit && !s_cyc && !m_ack) |=> (!m_ack && !s_cyc));

    // R5: a write still in flight for a second cycle gives no ack upstream
    a_r5_stall: assert property (@(posedge clk) disable iff (rst)
        (s_cyc && s_we && $past(s_cyc && s_we)) |-> !m_ack);

    // R6: read completion returns the sampled data with the acknowledge
    a_r6_read_data: assert property (@(posedge clk) disable iff (rst)
        (s_ack && s_stb && !s_we) |=> (m_ack && m_rdat == $past(s_rdat)));

    // R8: return data holds unless a read just completed
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !(s_ack && s_stb && !s_we) |=> $stable(m_rdat));
endmodule

// File: tb/test_posted_bridge.sv
module test_posted_bridge;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          m_cyc = 1'b0, m_stb = 1'b0, m_we = 1'b0;
    logic [AW-1:0] m_adr = '0;
    logic [DW-1:0] m_wdat = '0;
    logic          m_ack;
    logic [DW-1:0] m_rdat;
    logic          s_cyc, s_stb, s_we;
    logic [AW-1:0] s_adr;
    logic [DW-1:0] s_wdat;
    logic          s_ack = 1'b0;
    logic [DW-1:0] s_rdat = '0;

    posted_bridge i_posted_bridge (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    logic [DW-1:0] last_rd = '0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [AW-1:0] a);
        return (a & 32'hFFFF0000) == 32'h00020000;
    endfunction

    // Behavioural reference model, advanced on every rising edge
    bit            busy_w, busy_r, rdone, exp_ack;
    logic [DW-1:0] exp_rdat;
    logic [63:0]   wq[$];

    always @(posedge clk) begin
        if (rst) begin
            busy_w = 0; busy_r = 0; rdone = 0; exp_ack = 0; exp_rdat = '0;
        end else begin
            exp_ack = 0;
            if (rdone) rdone = 0;
            else if (busy_w) begin
                if (s_ack) busy_w = 0;
            end else if (busy_r) begin
                if (s_ack) begin busy_r = 0; rdone = 1; exp_ack = 1; exp_rdat = s_rdat; end
            end else if (m_cyc && m_stb && in_win(m_adr)) begin
                if (m_we) begin exp_ack = 1; busy_w = 1; wq.push_back({m_adr, m_wdat}); end
                else busy_r = 1;
            end
        end
    end

    // Per-cycle comparison and slave model, both at the falling edge
    int scnt = 0;
    int cyc_n = 0;
    initial begin
        forever begin
            @(negedge clk);
            cyc_n++;
            if (!rst) begin
                chk(m_ack == exp_ack, "R2 R3 R5 R7 m_ack", 64'(m_ack), 64'(exp_ack));
                chk(m_rdat == exp_rdat, "R6 R8 m_rdat", 64'(m_rdat), 64'(exp_rdat));
                chk(s_cyc == (busy_w || busy_r) && s_stb == s_cyc, "R2 R4 s_cyc", 64'(s_cyc), 64'(busy_w || busy_r));
                if (s_cyc) chk(s_we == busy_w, "R4 R6 s_we", 64'(s_we), 64'(busy_w));
            end
            // slave
            if (s_ack) begin
                s_ack = 0; scnt = 0;
            end else if (s_cyc && s_stb) begin
                scnt++;
                if (scnt >= lat) begin
                    s_ack = 1;
                    if (s_we) begin
                        chk(wq.size() > 0, "R4 unexpected write", 64'(wq.size()), 64'd1);
                        if (wq.size() > 0) begin
                            chk({s_adr, s_wdat} == wq[0], "R4 write order/content", {s_adr, s_wdat}, wq[0]);
                            void'(wq.pop_front());
                        end
                    end else begin
                        last_rd = s_adr * 3 + DW'(cyc_n);
                    end
                end
            end
            s_rdat = s_ack && !s_we ? last_rd : {16'hDEAD, 16'(cyc_n)};
        end
    end

    task automatic wait_ack(output int waits);
        waits = 0;
        forever begin
            @(negedge clk);
            waits++;
            if (m_ack || waits > 1000) break;
        end
        m_cyc = 0; m_stb = 0;
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output int waits);
        @(negedge clk);
        m_cyc = 1; m_stb = 1; m_we = 1; m_adr = a; m_wdat = d;
        wait_ack(waits);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output int waits);
        @(negedge clk);
        m_cyc = 1; m_stb = 1; m_we = 0; m_adr = a;
        wait_ack(waits);
        d = m_rdat;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w;
        logic [DW-1:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!m_ack && !s_cyc && !s_stb && m_rdat == 0, "R1 reset state", {m_ack, s_cyc, s_stb}, 64'd0);
        rst = 0;

        // lat 1: posted write, then read
        lat = 1;
        bus_wr(32'h0002_0010, 32'h1111_2222, w);
        chk(w == 1, "R3 posted ack delay", 64'(w), 64'd1);
        repeat (3) @(negedge clk);
        bus_rd(32'h0002_0020, d, w);
        chk(w == lat + 1, "R6 read latency", 64'(w), 64'(lat + 1));
        chk(d == last_rd, "R6 read data", d, last_rd);

        // lat 3: burst of posted writes, reads
        lat = 3;
        for (int i = 0; i < 3; i++) bus_wr(32'h0002_0100 + 32'(i * 4), 32'hA000_0000 + 32'(i), w);
        bus_rd(32'h0002_0104, d, w);
        chk(d == last_rd, "R6 read data lat3", d, last_rd);
        bus_rd(32'h0002_0FFC, d, w);
        chk(w == lat + 1, "R6 read latency lat3", 64'(w), 64'(lat + 1));

        // lat 6: second write issued while first is in flight
        repeat (4) @(negedge clk);
        lat = 6;
        bus_wr(32'h0002_0200, 32'hBEEF_0001, w);
        chk(w == 1, "R3 posted ack lat6", 64'(w), 64'd1);
        bus_wr(32'h0002_0204, 32'hBEEF_0002, w);
        chk(w == lat, "R5 stalled write", 64'(w), 64'(lat));

        // out of window request
        repeat (8) @(negedge clk);
        @(negedge clk);
        m_cyc = 1; m_stb = 1; m_we = 1; m_adr = 32'h0003_0000; m_wdat = 32'h5;
        repeat (6) begin
            @(negedge clk);
            chk(!m_ack && !s_cyc, "R2 outside window", {m_ack, s_cyc}, 64'd0);
        end
        m_cyc = 0; m_stb = 0;

        // lat 2: read, idle with busy s_rdat, write, read again
        lat = 2;
        bus_rd(32'h0002_0300, d, w);
        chk(d == last_rd, "R6 read data lat2", d, last_rd);
        repeat (6) @(negedge clk);
        chk(m_rdat == d, "R8 hold over idle", m_rdat, d);
        bus_wr(32'h0002_0304, 32'h7777_0000, w);
        repeat (4) @(negedge clk);
        chk(m_rdat == d, "R8 hold over write", m_rdat, d);
        bus_rd(32'h0002_0308, d, w);
        chk(d == last_rd, "R6 read after write", d, last_rd);

        repeat (10) @(negedge clk);
        chk(wq.size() == 0, "R4 all writes delivered", 64'(wq.size()), 64'd0);
        finish_run();
    end
endmodule